// File: doc/BRIEF.md
# Isochronous Audio Packet Deframer

This block takes the payload of one isochronous audio packet, presented one quadlet per beat on a valid/last stream, and turns it into per-channel audio words. The first two quadlets of every packet are a packet header; the block skips them, because no further common header follows them. After the header, every quadlet belongs to one channel in a fixed rotating order. The upper three bytes of each quadlet are a 24-bit audio value. The block emits that value with its channel index.

The low byte of a few channels carries timing side information instead of audio. These bytes hold a frame marker, a phase value, a 16-bit receive sample counter and a 16-bit transmit buffer size. The block collects them again for every sample and presents them as one sync record when the sample's last channel arrives. The block compares the counter in a packet's first sample with the counter of the last sample of the previous good packet. When they are not consecutive, it raises a drop pulse. A cycle without a packet on the bus is never an error. A packet whose payload does not end on a sample boundary is flagged, and its counter does not update the continuity reference.

Top module: `isodf_deframer`

## Requirements
- R1: While reset is low and in the cycle after reset is released, `aud_valid`, `sync_valid`, `drop_err` and `pkt_bad` are 0.
- R2: The first two quadlets of each packet are header quadlets and produce no audio word and no sync record.
- R3: Each payload quadlet accepted at a clock edge produces `aud_valid`=1 in the following cycle. In that cycle `aud_sample` equals bits 31:8 of the quadlet, and `aud_chan` counts 0, 1, …, NCH-1 and then restarts at 0 for each new sample.
- R4: The edge that accepts channel NCH-1 of a sample raises `sync_valid` for one cycle. The record carries the frame marker (bits 7:0 of channel 6) and the phase (bits 7:0 of channel 7) of that same sample.
- R5: The sync record's receive count is {channel 4 bits 7:0, channel 1 bits 7:0}, and its transmit buffer size is {channel 5 bits 7:0, channel 0 bits 7:0}.
- R6: The frame marker is taken again for every sample, so a value that changes between samples of one packet appears in each sample's own sync record.
- R7: `drop_err` pulses together with the sync record of a packet's first sample when that sample's receive count is not (reference + 1) mod 2^16. The count 0x0000 that follows 0xFFFF is consecutive.
- R8: Before any well-formed packet carrying samples has ended after reset, no reference exists and `drop_err` stays 0.
- R9: Cycles with `in_valid`=0, between packets or inside one, change nothing and produce no output strobe.
- R10: A packet that is malformed raises `pkt_bad` in the cycle after its last quadlet. A packet is malformed when it ends before its header is complete, or when its payload is not a whole number of NCH-quadlet samples. Such a packet does not change the reference.
- R11: A packet of header only is well formed. It raises no `pkt_bad` and leaves the reference unchanged.
- R12: The low bytes of channels 8 and above never affect any sync field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A quadlet is present this cycle |
| in_data | input | 32 | Packet quadlet |
| in_last | input | 1 | Quadlet is the last of its packet |
| aud_valid | output | 1 | Audio word valid |
| aud_chan | output | $clog2(NCH) | Channel index of the audio word |
| aud_sample | output | 24 | 24-bit audio value |
| sync_valid | output | 1 | Sync record valid, once per complete sample |
| sync_frame | output | 8 | Frame marker of the sample |
| sync_phase | output | 8 | Phase value of the sample |
| sync_rx_count | output | 16 | Receive sample counter |
| sync_tx_size | output | 16 | Transmit buffer size |
| drop_err | output | 1 | Counter discontinuity at a packet's first sample |
| pkt_bad | output | 1 | Packet length is malformed |

## Verification
Every result is registered once. An audio word appears in the cycle after its quadlet is accepted. A sync record and any drop pulse appear in the cycle after channel NCH-1 is accepted, and `pkt_bad` appears in the cycle after the last quadlet. The bench drives each beat just after a rising edge and checks that beat's results one time unit after the next rising edge. Every check therefore sees exactly the edge that consumed the quadlet. Idle beats are checked in the same slot for silence.

// File: rtl/isodf_pkg.sv
package isodf_pkg;

  localparam int QUAD_W = 32;
  localparam int AUD_W  = 24;
  localparam int NSLOT  = 6;

  // channels whose low byte carries side information
  localparam int CH_TX_LO  = 0;
  localparam int CH_CNT_LO = 1;
  localparam int CH_CNT_HI = 4;
  localparam int CH_TX_HI  = 5;
  localparam int CH_FRAME  = 6;
  localparam int CH_PHASE  = 7;

  typedef logic [15:0] cnt16_t;

  typedef struct packed {
    logic [7:0] frame;
    logic [7:0] phase;
    cnt16_t     rx_count;
    cnt16_t     tx_size;
  } side_t;

  // slot k of the capture bank listens to this channel
  function automatic int slot_chan(int k);
    case (k)
      0:       return CH_TX_LO;
      1:       return CH_TX_HI;
      2:       return CH_CNT_LO;
      3:       return CH_CNT_HI;
      4:       return CH_FRAME;
      default: return CH_PHASE;
    endcase
  endfunction

  function automatic logic [AUD_W-1:0] audio_part(logic [QUAD_W-1:0] q);
    return q[QUAD_W-1:QUAD_W-AUD_W];
  endfunction

  function automatic logic [7:0] side_part(logic [QUAD_W-1:0] q);
    return q[7:0];
  endfunction

  function automatic cnt16_t cnt_succ(cnt16_t c);
    return c + 16'd1;
  endfunction

  // true when now_c does not follow prev_c in the mod-2^16 sequence
  function automatic logic cnt_gap(cnt16_t prev_c, cnt16_t now_c);
    return now_c != cnt_succ(prev_c);
  endfunction

endpackage

// File: rtl/isodf_slot_tracker.sv
module isodf_slot_tracker #(
  parameter  int NCH   = 28,
  parameter  int HDR_Q = 2,
  localparam int CH_W  = $clog2(NCH),
  localparam int HW    = $clog2(HDR_Q + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat,
  input  logic            last,
  output logic            is_hdr,
  output logic [CH_W-1:0] ch,
  output logic            smp_end,
  output logic            first_smp,
  output logic            hdr_end
);

  localparam logic [HW-1:0]   HDR_LIM = HW'(HDR_Q);
  localparam logic [HW-1:0]   HDR_FIN = HW'(HDR_Q - 1);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

  logic [HW-1:0]   hcnt_q;
  logic [CH_W-1:0] ccnt_q;
  logic            first_q;

  assign is_hdr    = (hcnt_q != HDR_LIM);
  assign ch        = ccnt_q;
  assign smp_end   = !is_hdr && (ccnt_q == CH_LAST);
  assign first_smp = first_q;
  assign hdr_end   = (hcnt_q == HDR_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      ccnt_q  <= '0;
      first_q <= 1'b1;
    end else if (beat) begin
      if (last) begin
        hcnt_q  <= '0;
        ccnt_q  <= '0;
        first_q <= 1'b1;
      end else if (is_hdr) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        ccnt_q <= smp_end ? '0 : ccnt_q + 1'b1;
        if (smp_end) first_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/isodf_side_capture.sv
module isodf_side_capture
  import isodf_pkg::*;
#(
  parameter  int NCH  = 28,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [CH_W-1:0] ch,
  input  logic [7:0]      lowb,
  output side_t           side
);

  logic [NSLOT*8-1:0] bank;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [CH_W-1:0] MY_CH = CH_W'(slot_chan(k));
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                   b_q <= '0;
      else if (take && ch == MY_CH) b_q <= lowb;
    end
    assign bank[k*8 +: 8] = b_q;
  end

  assign side.tx_size  = {bank[15:8],  bank[7:0]};
  assign side.rx_count = {bank[31:24], bank[23:16]};
  assign side.frame    = bank[39:32];
  assign side.phase    = bank[47:40];

endmodule

// File: rtl/isodf_gap_monitor.sv
module isodf_gap_monitor
  import isodf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   smp_done,
  input  logic   first_smp,
  input  logic   whole_end,
  input  cnt16_t cur_cnt,
  output logic   drop_q,
  output logic   base_ok,
  output cnt16_t base_cnt
);

  logic hit;
  assign hit = smp_done && first_smp && base_ok && cnt_gap(base_cnt, cur_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_q   <= 1'b0;
      base_ok  <= 1'b0;
      base_cnt <= '0;
    end else begin
      drop_q <= hit;
      if (whole_end) begin
        base_ok  <= 1'b1;
        base_cnt <= cur_cnt;
      end
    end
  end

endmodule

// File: rtl/isodf_deframer.sv
module isodf_deframer
  import isodf_pkg::*;
#(
  parameter  int NCH   = 28,
  parameter  int HDR_Q = 2,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [QUAD_W-1:0] in_data,
  input  logic              in_last,
  output logic              aud_valid,
  output logic [CH_W-1:0]   aud_chan,
  output logic [AUD_W-1:0]  aud_sample,
  output logic              sync_valid,
  output logic [7:0]        sync_frame,
  output logic [7:0]        sync_phase,
  output logic [15:0]       sync_rx_count,
  output logic [15:0]       sync_tx_size,
  output logic              drop_err,
  output logic              pkt_bad
);

  logic            trk_is_hdr;
  logic [CH_W-1:0] trk_ch;
  logic            trk_smp_end;
  logic            trk_first;
  logic            trk_hdr_end;
  side_t           cap_side;
  logic            mon_base_ok;
  cnt16_t          mon_base_cnt;

  logic pay_beat, smp_done, pkt_fin, pkt_whole, pkt_ok;

  assign pay_beat  = in_valid && !trk_is_hdr;
  assign smp_done  = in_valid && trk_smp_end;
  assign pkt_fin   = in_valid && in_last;
  assign pkt_whole = pkt_fin && trk_smp_end;
  assign pkt_ok    = trk_hdr_end || trk_smp_end;

  isodf_slot_tracker #(.NCH(NCH), .HDR_Q(HDR_Q)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (in_valid),
    .last      (in_last),
    .is_hdr    (trk_is_hdr),
    .ch        (trk_ch),
    .smp_end   (trk_smp_end),
    .first_smp (trk_first),
    .hdr_end   (trk_hdr_end)
  );

  isodf_side_capture #(.NCH(NCH)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (pay_beat),
    .ch    (trk_ch),
    .lowb  (side_part(in_data)),
    .side  (cap_side)
  );

  isodf_gap_monitor u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_done  (smp_done),
    .first_smp (trk_first),
    .whole_end (pkt_whole),
    .cur_cnt   (cap_side.rx_count),
    .drop_q    (drop_err),
    .base_ok   (mon_base_ok),
    .base_cnt  (mon_base_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aud_valid     <= 1'b0;
      aud_chan      <= '0;
      aud_sample    <= '0;
      sync_valid    <= 1'b0;
      sync_frame    <= '0;
      sync_phase    <= '0;
      sync_rx_count <= '0;
      sync_tx_size  <= '0;
      pkt_bad       <= 1'b0;
    end else begin
      aud_valid  <= pay_beat;
      sync_valid <= smp_done;
      pkt_bad    <= pkt_fin && !pkt_ok;
      if (pay_beat) begin
        aud_chan   <= trk_ch;
        aud_sample <= audio_part(in_data);
      end
      if (smp_done) begin
        sync_frame    <= cap_side.frame;
        sync_phase    <= cap_side.phase;
        sync_rx_count <= cap_side.rx_count;
        sync_tx_size  <= cap_side.tx_size;
      end
    end
  end

endmodule

// File: rtl/isodf_deframer_chk.sv
module isodf_deframer_chk #(
  parameter  int NCH  = 28,
  localparam int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            aud_valid,
  input logic [CH_W-1:0] aud_chan,
  input logic            sync_valid,
  input logic            drop_err,
  input logic            pkt_bad,
  input logic            hdr_phase,
  input logic            base_ok,
  input logic [15:0]     base_cnt
);

  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

  a_r2_header_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_phase) |=> !aud_valid && !sync_valid);

  a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid |-> aud_chan <= CH_LAST);

  a_r4_sync_on_last_chan: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> aud_valid && aud_chan == CH_LAST);

  a_r7_drop_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> sync_valid);

  a_r8_no_drop_without_base: assert property (@(posedge clk) disable iff (!rst_n)
    !base_ok |=> !drop_err);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !aud_valid && !sync_valid && !drop_err && !pkt_bad);

  a_r10_bad_not_on_sample_end: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_bad |-> !sync_valid);

  a_r10_base_held_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_bad |-> $stable(base_cnt));

endmodule

bind isodf_deframer isodf_deframer_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .aud_valid  (aud_valid),
  .aud_chan   (aud_chan),
  .sync_valid (sync_valid),
  .drop_err   (drop_err),
  .pkt_bad    (pkt_bad),
  .hdr_phase  (trk_is_hdr),
  .base_ok    (mon_base_ok),
  .base_cnt   (mon_base_cnt)
);

// File: tb/isodf_deframer_tb_top.sv
module isodf_deframer_tb_top;

  localparam int CLK_P = 10;
  localparam int NCH   = 28;
  localparam int CW    = $clog2(NCH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   in_data;
  logic          in_last;
  logic          aud_valid;
  logic [CW-1:0] aud_chan;
  logic [23:0]   aud_sample;
  logic          sync_valid;
  logic [7:0]    sync_frame, sync_phase;
  logic [15:0]   sync_rx_count, sync_tx_size;
  logic          drop_err, pkt_bad;

  int vectors = 0;
  int misses  = 0;

  // bench model of the continuity reference
  bit          ref_ok = 1'b0;
  logic [15:0] ref_c  = '0;

  always #(CLK_P/2) clk = ~clk;

  isodf_deframer #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .aud_valid(aud_valid), .aud_chan(aud_chan),
    .aud_sample(aud_sample), .sync_valid(sync_valid), .sync_frame(sync_frame),
    .sync_phase(sync_phase), .sync_rx_count(sync_rx_count),
    .sync_tx_size(sync_tx_size), .drop_err(drop_err), .pkt_bad(pkt_bad)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk(tag, {28'd0, aud_valid, sync_valid, drop_err, pkt_bad}, 32'd0);
  endtask

  task automatic beat(input logic [31:0] d, input bit lst);
    in_valid = 1'b1; in_data = d; in_last = lst;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      quiet("R9 idle cycle");
    end
  endtask

  function automatic logic [7:0] low_of(int s, int c, logic [15:0] cnt0, logic [7:0] frm0);
    logic [15:0] cnt = cnt0 + 16'(s);
    logic [15:0] tx  = cnt ^ 16'h5A5A;
    case (c)
      0: return tx[7:0];
      1: return cnt[7:0];
      4: return cnt[15:8];
      5: return tx[15:8];
      6: return frm0 + 8'(s);
      7: return 8'h40 + 8'(3 * s);
      default: return 8'hE0 ^ 8'(c);   // foreign bytes, must not leak (R12)
    endcase
  endfunction

  // hq header quadlets, nsmp samples, trunc quadlets removed from the end
  task automatic send_pkt(input int hq, input int nsmp, input int trunc,
                          input logic [15:0] cnt0, input logic [7:0] frm0,
                          input int gap_every);
    int  npay = (hq < 2) ? 0 : nsmp * NCH - trunc;
    bit  bad  = (hq < 2) || (trunc > 0);
    for (int h = 0; h < hq; h++) begin
      beat(32'hC0DE0000 | 32'(h), (h == hq - 1) && (npay == 0));
      chk("R2 header aud_valid", {31'd0, aud_valid}, 32'd0);
      chk("R2 header sync_valid", {31'd0, sync_valid}, 32'd0);
      if (h == hq - 1 && npay == 0)
        chk(bad ? "R10 short pkt_bad" : "R11 header-only pkt_bad", {31'd0, pkt_bad}, {31'd0, bad});
    end
    for (int p = 0; p < npay; p++) begin
      int s = p / NCH;
      int c = p % NCH;
      logic [23:0] up = {8'(s * 7 + 1), 8'(c), 8'h3C ^ 8'(s)};
      logic [15:0] cnt = cnt0 + 16'(s);
      bit endp = (p == npay - 1);
      bit exp_drop = (c == NCH - 1) && (s == 0) && ref_ok && (cnt0 != ref_c + 16'd1);
      beat({up, low_of(s, c, cnt0, frm0)}, endp);
      chk("R3 aud_valid", {31'd0, aud_valid}, 32'd1);
      chk("R3 aud_chan", 32'(aud_chan), 32'(c));
      chk("R3 aud_sample", {8'd0, aud_sample}, {8'd0, up});
      chk("R4 sync_valid", {31'd0, sync_valid}, {31'd0, c == NCH - 1});
      if (c == NCH - 1) begin
        chk("R6 sync_frame per sample", {24'd0, sync_frame}, {24'd0, frm0 + 8'(s)});
        chk("R4 sync_phase", {24'd0, sync_phase}, {24'd0, 8'h40 + 8'(3 * s)});
        chk("R5 R12 sync_rx_count", {16'd0, sync_rx_count}, {16'd0, cnt});
        chk("R5 R12 sync_tx_size", {16'd0, sync_tx_size}, {16'd0, cnt ^ 16'h5A5A});
      end
      chk(ref_ok ? "R7 drop_err" : "R8 drop_err without reference",
          {31'd0, drop_err}, {31'd0, exp_drop});
      if (endp) chk("R10 pkt_bad at end", {31'd0, pkt_bad}, {31'd0, bad});
      else      chk("R10 pkt_bad mid packet", {31'd0, pkt_bad}, 32'd0);
      if (gap_every > 0 && (p % gap_every) == 0 && !endp) idle(1);
    end
    if (!bad && npay > 0) begin
      ref_ok = 1'b1;
      ref_c  = cnt0 + 16'(nsmp - 1);
    end
    idle(2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #1 quiet("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    quiet("R1 after reset");
  endtask

  task automatic t_first_and_contig();
    send_pkt(2, 7, 0, 16'd100, 8'h10, 0);   // R8: no reference yet
    send_pkt(2, 7, 0, 16'd107, 8'h20, 5);   // R9: idle cycles inside packet
  endtask

  task automatic t_drop_and_wrap();
    send_pkt(2, 7, 0, 16'd120, 8'h30, 0);   // R7: gap 107..113 -> 120
    send_pkt(2, 6, 0, 16'hFFFA, 8'h40, 0);  // R7: discontinuity again
    send_pkt(2, 7, 0, 16'h0000, 8'h50, 0);  // R7: 0xFFFF -> 0x0000 is consecutive
  endtask

  task automatic t_malformed();
    send_pkt(2, 3, 5, 16'd7, 8'h60, 0);     // R10: truncated payload
    send_pkt(2, 2, 0, 16'd7, 8'h70, 0);     // R10: reference still 6
    send_pkt(1, 0, 0, 16'd0, 8'h00, 0);     // R10: ends inside header
  endtask

  task automatic t_header_only();
    send_pkt(2, 0, 0, 16'd0, 8'h00, 0);     // R11
    send_pkt(2, 1, 0, 16'd9, 8'h80, 0);     // R11: reference still 8
    send_pkt(2, 4, 0, 16'd11, 8'h90, 3);    // R7: one sample missed
  endtask

  initial begin
    #(CLK_P * 200000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    t_reset();
    t_first_and_contig();
    t_drop_and_wrap();
    t_malformed();
    t_header_only();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule